// File: doc/BRIEF.md
# Word-Store Command Controller

This block sits on a byte-wide host register bus and manages a small store of 16-bit words, standing in for a word-organised serial non-volatile memory. The host loads a 16-bit data buffer one byte at a time and a 16-bit command word one byte at a time. It then writes a control byte that starts exactly one operation.

The operation is one of the following:
- read a word into the buffer;
- store the buffer at a word address;
- clear the whole array;
- fill the whole array from the buffer;
- set or clear a write-protect latch.

The address field and the opcode field sit at different positions in the command word, depending on a geometry input. Large geometry has 1024 words and small geometry has 64 words. Each operation takes effect on the clock edge that accepts the control byte. A status read returns the last control byte with acknowledge bits merged in.

The host port is a plain register bus: one write or one read per cycle, never stalled. The block therefore has no valid/ready flow and no back-pressure.

Top module: `wordstore_cmd_ctrl`

## Requirements
- R1: Register select 0 writes the low data-buffer byte and select 1 writes the high byte. Each write replaces only its own half, and both read back on the same selects.
- R2: With `large_mode`=1 the opcode is command bits [11:10] and the word address is bits [9:0]. With `large_mode`=0 the opcode is bits [7:6] and the address is bits [5:0]. Command bits above the opcode are ignored. Command bytes are written on select 2 (low) and select 3 (high).
- R3: Opcode 00 with control bit 6 runs an extended operation, chosen by the two address bits just below the opcode: 00 clears the write-protect latch, 01 fills, 10 erases, 11 sets the latch. Control bit 6 with a non-zero opcode does nothing.
- R4: In the control byte (select 4), bit 6 takes priority over bit 5, which takes priority over bit 4. Only the winning operation is performed. Plain writes and reads do not look at the opcode field.
- R5: A write (bit 5) stores the data buffer at the decoded address only while the latch is set. Otherwise it changes nothing.
- R6: A read (bit 4) loads the addressed word into the data buffer.
- R7: Reading select 4 returns the last control byte, ORed with 0x02 if its bit 5 is set, else with 0x01 if its bit 4 is set, else with 0x03.
- R8: Erase clears every word of the active geometry to zero, whatever the latch holds. In small geometry, words 64 and up keep their contents.
- R9: Fill writes the data buffer into every word of the active geometry, but only while the latch is set.
- R10: After reset, the latch is clear and the buffer, command word, control byte and every array word are zero.
- R11: The effect of a control write is visible on reads starting with the cycle after the edge that accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| large_mode | input | 1 | 1 selects 1024-word geometry, 0 selects 64-word geometry |
| wr_en | input | 1 | Host register write strobe |
| wr_sel | input | 3 | Register select for writes |
| wr_data | input | 8 | Host write byte |
| rd_sel | input | 3 | Register select for reads |
| rd_data | output | 8 | Combinational read byte |

## Verification
The assertions assume that `wr_sel` and `rd_sel` only carry the codes 0 to 4 while strobed. They also assume `large_mode` is steady in any cycle that carries a control write. The bench changes the geometry input and every register input only on the falling edge, and issues one register access at a time. It therefore never presents an out-of-range select or a geometry change on the same edge as an operation.

// File: rtl/wsc_pkg.sv
package wsc_pkg;
  localparam int HOST_W = 8;
  localparam int SEL_W  = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_DLO = 3'd0,
    SEL_DHI = 3'd1,
    SEL_CLO = 3'd2,
    SEL_CHI = 3'd3,
    SEL_CTL = 3'd4
  } reg_sel_e;

  localparam int CTL_EXT = 6;
  localparam int CTL_WR  = 5;
  localparam int CTL_RD  = 4;

  typedef enum logic [1:0] {
    SUB_LOCK   = 2'b00,
    SUB_FILL   = 2'b01,
    SUB_CLEAR  = 2'b10,
    SUB_UNLOCK = 2'b11
  } sub_op_e;

  localparam logic [1:0] OPC_EXT = 2'b00;
endpackage

// File: rtl/wsc_cmd_decode.sv
module wsc_cmd_decode #(
  parameter int CMD_W = 16,
  parameter int AW_L  = 10,
  parameter int AW_S  = 6
) (
  input  logic            large_mode,
  input  logic [CMD_W-1:0] cmd,
  output logic [1:0]       opc,
  output logic [1:0]       sub,
  output logic [AW_L-1:0]  addr
);
  localparam int OPC_L = AW_L;
  localparam int OPC_S = AW_S;

  always_comb begin
    if (large_mode) begin
      opc  = cmd[OPC_L+1:OPC_L];
      sub  = cmd[AW_L-1:AW_L-2];
      addr = cmd[AW_L-1:0];
    end else begin
      opc  = cmd[OPC_S+1:OPC_S];
      sub  = cmd[AW_S-1:AW_S-2];
      addr = AW_L'(cmd[AW_S-1:0]);
    end
  end
endmodule

// File: rtl/wsc_op_seq.sv
module wsc_op_seq
  import wsc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [HOST_W-1:0] ctl,
  input  logic [1:0]        opc,
  input  logic [1:0]        sub,
  output logic              do_write,
  output logic              do_read,
  output logic              do_fill,
  output logic              do_clear,
  output logic              wen_q
);
  logic ext_hit, wr_hit, rd_hit, ext_ok;

  always_comb begin
    ext_hit  = go && ctl[CTL_EXT];
    wr_hit   = go && !ctl[CTL_EXT] && ctl[CTL_WR];
    rd_hit   = go && !ctl[CTL_EXT] && !ctl[CTL_WR] && ctl[CTL_RD];
    ext_ok   = ext_hit && (opc == OPC_EXT);
    do_write = wr_hit && wen_q;
    do_read  = rd_hit;
    do_fill  = ext_ok && (sub == SUB_FILL) && wen_q;
    do_clear = ext_ok && (sub == SUB_CLEAR);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wen_q <= 1'b0;
    end else if (ext_ok && sub == SUB_UNLOCK) begin
      wen_q <= 1'b1;
    end else if (ext_ok && sub == SUB_LOCK) begin
      wen_q <= 1'b0;
    end
  end
endmodule

// File: rtl/wsc_word_store.sv
module wsc_word_store #(
  parameter int DW   = 16,
  parameter int AW_L = 10,
  parameter int AW_S = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            large_mode,
  input  logic            wr,
  input  logic            fill,
  input  logic            clr,
  input  logic [AW_L-1:0] addr,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata
);
  localparam int WORDS_L = 1 << AW_L;
  localparam int WORDS_S = 1 << AW_S;

  logic [DW-1:0] mem_q [WORDS_L];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS_L; i++) mem_q[i] <= '0;
    end else if (clr || fill) begin
      for (int i = 0; i < WORDS_L; i++) begin
        if (large_mode || i < WORDS_S) mem_q[i] <= clr ? '0 : wdata;
      end
    end else if (wr) begin
      mem_q[addr] <= wdata;
    end
  end

  assign rdata = mem_q[addr];
endmodule

// File: rtl/wordstore_cmd_ctrl.sv
module wordstore_cmd_ctrl
  import wsc_pkg::*;
#(
  parameter int DW   = 16,
  parameter int AW_L = 10,
  parameter int AW_S = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              large_mode,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [HOST_W-1:0] wr_data,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [HOST_W-1:0] rd_data
);
  localparam int CMD_W = 2 * HOST_W;

  logic [DW-1:0]     dbuf_q;
  logic [CMD_W-1:0]  cmd_q;
  logic [HOST_W-1:0] ctrl_q;
  logic              ctrl_wr;
  logic [1:0]        opc, sub;
  logic [AW_L-1:0]   waddr;
  logic              do_write, do_read, do_fill, do_clear, wen_q;
  logic [DW-1:0]     word_rd;
  logic [1:0]        ack;

  assign ctrl_wr = wr_en && (wr_sel == SEL_CTL);

  wsc_cmd_decode #(.CMD_W(CMD_W), .AW_L(AW_L), .AW_S(AW_S)) u_dec (
    .large_mode(large_mode), .cmd(cmd_q), .opc(opc), .sub(sub), .addr(waddr)
  );

  wsc_op_seq u_seq (
    .clk(clk), .rst_n(rst_n), .go(ctrl_wr), .ctl(wr_data), .opc(opc), .sub(sub),
    .do_write(do_write), .do_read(do_read), .do_fill(do_fill),
    .do_clear(do_clear), .wen_q(wen_q)
  );

  wsc_word_store #(.DW(DW), .AW_L(AW_L), .AW_S(AW_S)) u_store (
    .clk(clk), .rst_n(rst_n), .large_mode(large_mode), .wr(do_write),
    .fill(do_fill), .clr(do_clear), .addr(waddr), .wdata(dbuf_q), .rdata(word_rd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dbuf_q <= '0;
      cmd_q  <= '0;
      ctrl_q <= '0;
    end else begin
      if (wr_en && wr_sel == SEL_DLO) dbuf_q[HOST_W-1:0] <= wr_data;
      else if (wr_en && wr_sel == SEL_DHI) dbuf_q[DW-1:HOST_W] <= wr_data;
      else if (do_read) dbuf_q <= word_rd;
      if (wr_en && wr_sel == SEL_CLO) cmd_q[HOST_W-1:0] <= wr_data;
      if (wr_en && wr_sel == SEL_CHI) cmd_q[CMD_W-1:HOST_W] <= wr_data;
      if (ctrl_wr) ctrl_q <= wr_data;
    end
  end

  always_comb begin
    if (ctrl_q[CTL_WR])      ack = 2'b10;
    else if (ctrl_q[CTL_RD]) ack = 2'b01;
    else                     ack = 2'b11;
  end

  always_comb begin
    case (rd_sel)
      SEL_DLO: rd_data = dbuf_q[HOST_W-1:0];
      SEL_DHI: rd_data = dbuf_q[DW-1:HOST_W];
      SEL_CLO: rd_data = cmd_q[HOST_W-1:0];
      SEL_CHI: rd_data = cmd_q[CMD_W-1:HOST_W];
      SEL_CTL: rd_data = ctrl_q | HOST_W'(ack);
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/wsc_chk.sv
module wsc_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [2:0]  wr_sel,
  input logic [7:0]  wr_data,
  input logic [2:0]  rd_sel,
  input logic [7:0]  rd_data,
  input logic [15:0] dbuf_q,
  input logic [7:0]  ctrl_q,
  input logic        wen_q
);
  // R7
  status_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel == 3'd4) |-> (rd_data[1:0] != 2'b00));

  // R1
  dlo_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 3'd0) |=>
      (dbuf_q[15:8] == $past(dbuf_q[15:8]) && dbuf_q[7:0] == $past(wr_data)));

  // R3
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_sel == 3'd4 && wr_data[6]) |=> $stable(wen_q));

  // R4
  prio_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 3'd4 && (wr_data[6] || wr_data[5])) |=> $stable(dbuf_q));

  // R6
  dbuf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (wr_sel == 3'd0 || wr_sel == 3'd1 || (wr_sel == 3'd4 && wr_data[4])))
      |=> $stable(dbuf_q));

  // R11
  ctrl_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 3'd4) |=> (ctrl_q == $past(wr_data)));
endmodule

bind wordstore_cmd_ctrl wsc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .rd_sel(rd_sel), .rd_data(rd_data), .dbuf_q(dbuf_q), .ctrl_q(ctrl_q), .wen_q(wen_q)
);

// File: tb/wordstore_cmd_ctrl_tb.sv
`timescale 1ns/1ps
module wordstore_cmd_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       large_mode = 1'b1;
  logic       wr_en = 1'b0;
  logic [2:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_sel = '0;
  logic [7:0] rd_data;
  int pass_cnt = 0;
  int fail_cnt = 0;
  bit done = 0;

  always #4 clk = ~clk;

  wordstore_cmd_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .large_mode(large_mode), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data)
  );

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    if (got === exp) pass_cnt++;
    else begin
      fail_cnt++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] sel, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] sel, output logic [7:0] v);
    rd_sel = sel; #1; v = rd_data;
  endtask

  task automatic rd_buf(output logic [15:0] v);
    logic [7:0] lo, hi;
    reg_rd(3'd0, lo); reg_rd(3'd1, hi); v = {hi, lo};
  endtask

  task automatic set_buf(input logic [15:0] d);
    reg_wr(3'd0, d[7:0]); reg_wr(3'd1, d[15:8]);
  endtask

  task automatic set_cmd(input logic [15:0] c);
    reg_wr(3'd2, c[7:0]); reg_wr(3'd3, c[15:8]);
  endtask

  task automatic set_mode(input logic m);
    @(negedge clk); large_mode = m;
  endtask

  task automatic wr_word(input logic m, input logic [9:0] a, input logic [15:0] d);
    set_mode(m); set_buf(d);
    set_cmd(m ? (16'h0400 | 16'(a)) : (16'h0040 | 16'(a[5:0])));
    reg_wr(3'd4, 8'h20);
  endtask

  task automatic rd_word(input logic m, input logic [9:0] a, output logic [15:0] v);
    set_mode(m);
    set_cmd(m ? (16'h0800 | 16'(a)) : (16'h0080 | 16'(a[5:0])));
    reg_wr(3'd4, 8'h10);
    rd_buf(v);
  endtask

  task automatic ext_op(input logic m, input logic [1:0] sub);
    set_mode(m);
    set_cmd(m ? {6'b0, sub, 8'h00} : {8'h00, 2'b00, sub, 4'h0});
    reg_wr(3'd4, 8'h40);
  endtask

  task automatic t_reset();
    logic [7:0] s; logic [15:0] v;
    reg_rd(3'd4, s); check("R10/R7 reset status", 16'(s), 16'h0003);
    rd_buf(v); check("R10 reset buffer", v, 16'h0000);
    rd_word(1'b1, 10'd5, v); check("R10 reset word", v, 16'h0000);
  endtask

  task automatic t_bytes();
    logic [15:0] v;
    set_buf(16'h1234); rd_buf(v); check("R1 both halves", v, 16'h1234);
    reg_wr(3'd0, 8'hAB); rd_buf(v); check("R1 low only", v, 16'h12AB);
    reg_wr(3'd1, 8'hCD); rd_buf(v); check("R1 high only", v, 16'hCDAB);
  endtask

  task automatic t_locked_write();
    logic [15:0] v;
    wr_word(1'b1, 10'd5, 16'h1111);
    rd_word(1'b1, 10'd5, v); check("R5 write dropped while locked", v, 16'h0000);
  endtask

  task automatic t_unlock_write();
    logic [15:0] v; logic [7:0] s;
    ext_op(1'b1, 2'b11);
    wr_word(1'b1, 10'd5, 16'hBEEF);
    reg_rd(3'd4, s); check("R7 status after write", 16'(s), 16'h0022);
    set_buf(16'h0000);
    rd_word(1'b1, 10'd5, v); check("R6 read loads word (R11)", v, 16'hBEEF);
    reg_rd(3'd4, s); check("R7 status after read", 16'(s), 16'h0011);
  endtask

  task automatic t_priority();
    logic [15:0] v; logic [7:0] s;
    set_mode(1'b1); set_buf(16'h5555); set_cmd(16'h0807);
    reg_wr(3'd4, 8'h30);
    rd_buf(v); check("R4 write wins over read", v, 16'h5555);
    reg_rd(3'd4, s); check("R7 status bit5 over bit4", 16'(s), 16'h0032);
    rd_word(1'b1, 10'd7, v); check("R4 opcode ignored for write", v, 16'h5555);
    set_buf(16'h7777); set_cmd(16'h0000);
    reg_wr(3'd4, 8'h70);
    reg_rd(3'd4, s); check("R7 status 0x70", 16'(s), 16'h0072);
    rd_word(1'b1, 10'd0, v); check("R4 extended wins over write", v, 16'h0000);
    wr_word(1'b1, 10'd8, 16'h7777);
    rd_word(1'b1, 10'd8, v); check("R3 lock cleared latch", v, 16'h0000);
  endtask

  task automatic t_bad_ext();
    logic [15:0] v;
    set_mode(1'b1); set_cmd(16'h0700); reg_wr(3'd4, 8'h40);
    wr_word(1'b1, 10'd9, 16'h0001);
    rd_word(1'b1, 10'd9, v); check("R3 non-zero opcode ext ignored", v, 16'h0000);
  endtask

  task automatic t_small();
    logic [15:0] v;
    ext_op(1'b0, 2'b11);
    set_mode(1'b0); set_buf(16'h0A0A); set_cmd(16'hF043); reg_wr(3'd4, 8'h20);
    rd_word(1'b1, 10'd3, v); check("R2 small decode addr 3", v, 16'h0A0A);
    wr_word(1'b1, 10'd100, 16'h6464);
    wr_word(1'b1, 10'd1023, 16'h3FF3);
    rd_word(1'b1, 10'd1023, v); check("R2 large decode top word", v, 16'h3FF3);
  endtask

  task automatic t_erase();
    logic [15:0] v;
    ext_op(1'b0, 2'b10);
    rd_word(1'b1, 10'd3, v); check("R8 small erase clears low word", v, 16'h0000);
    rd_word(1'b1, 10'd100, v); check("R8 small erase keeps word 100", v, 16'h6464);
    ext_op(1'b1, 2'b00);
    ext_op(1'b1, 2'b10);
    rd_word(1'b1, 10'd100, v); check("R8 large erase while locked", v, 16'h0000);
    rd_word(1'b1, 10'd1023, v); check("R8 large erase top word", v, 16'h0000);
  endtask

  task automatic t_fill();
    logic [15:0] v;
    set_buf(16'h9999); ext_op(1'b1, 2'b01);
    rd_word(1'b1, 10'd10, v); check("R9 fill ignored while locked", v, 16'h0000);
    ext_op(1'b1, 2'b11);
    set_buf(16'hC3C3); ext_op(1'b1, 2'b01);
    rd_word(1'b1, 10'd0, v); check("R9 large fill word 0", v, 16'hC3C3);
    rd_word(1'b1, 10'd1023, v); check("R9 large fill top word", v, 16'hC3C3);
    set_buf(16'h1234); ext_op(1'b0, 2'b01);
    rd_word(1'b1, 10'd63, v); check("R9 small fill word 63", v, 16'h1234);
    rd_word(1'b1, 10'd64, v); check("R9 small fill leaves word 64", v, 16'hC3C3);
  endtask

  task automatic t_status_none();
    logic [7:0] s;
    reg_wr(3'd4, 8'h00); reg_rd(3'd4, s); check("R7 no op bits", 16'(s), 16'h0003);
    reg_wr(3'd4, 8'h80); reg_rd(3'd4, s); check("R7 bit7 kept", 16'(s), 16'h0083);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_bytes();
    t_locked_write();
    t_unlock_write();
    t_priority();
    t_bad_ext();
    t_small();
    t_erase();
    t_fill();
    t_status_none();
    done = 1;
    $display("%0d/%0d checks passed", pass_cnt, pass_cnt + fail_cnt);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fail_cnt++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", pass_cnt, pass_cnt + fail_cnt);
      $finish;
    end
  end
endmodule